// File: doc/BRIEF.md
# Oldest and Youngest Thread Selector

This block watches up to four hardware threads that share an in-order retirement window. For each thread it receives four things: whether the thread is active, whether it holds any entries, the sequence number of its oldest entry and the sequence number of its youngest entry. From these it works out two results. The global head is the thread that owns the oldest instruction overall. The global tail is the thread that owns the youngest instruction overall. Each result comes with its sequence number and a valid flag.

Both results are held in registers, and each one is refreshed only by its own strobe. The retirement logic pulses the head strobe after every entry it retires. The squash logic pulses the tail strobe after a squash has removed the entry that was the tail.

A selection considers only threads that are both active and non-empty. It scans them from thread 0 upward. The first such thread is taken as the starting choice without any comparison. A later thread displaces that choice only when its number is strictly better, so equal numbers keep the lower-indexed thread.

Top module: `thread_end_select`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, both valid flags, both thread indices and both sequence numbers read zero.
- R2: In the cycle after `retire_evt` is sampled high, `head_tid` and `head_seq` name the eligible thread with the smallest oldest-entry sequence number, taken from the inputs at that edge. `head_valid` is 1 in that cycle.
- R3: When two or more eligible threads share the smallest oldest-entry number, the head is the lowest-numbered of them.
- R4: In the cycle after `tail_evt` is sampled high, `tail_tid` and `tail_seq` name the eligible thread with the largest youngest-entry sequence number. `tail_valid` is 1 in that cycle.
- R5: When two or more eligible threads share the largest youngest-entry number, the tail is the lowest-numbered of them.
- R6: A thread is eligible only when both its `thr_active` bit and its `thr_nonempty` bit are 1. An ineligible thread never becomes head or tail, whatever its sequence numbers.
- R7: If an update strobe arrives while no thread is eligible, the matching valid flag, thread index and sequence number all read 0 in the following cycle.
- R8: While its strobe is low, each result keeps its value, whatever the other inputs do.
- R9: The two strobes act independently. When both are high in the same cycle, both results update. Sequence numbers are 16-bit unsigned values compared without any wraparound handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_active | input | NTHR | Active flag, one bit per thread |
| thr_nonempty | input | NTHR | Thread holds at least one entry, one bit per thread |
| thr_old_seq | input | NTHR*SEQ_W | Oldest-entry sequence number of each thread; thread i occupies bits [i*SEQ_W +: SEQ_W] |
| thr_young_seq | input | NTHR*SEQ_W | Youngest-entry sequence number of each thread, packed the same way |
| retire_evt | input | 1 | Refresh the head result |
| tail_evt | input | 1 | Refresh the tail result |
| head_valid | output | 1 | Head result names a thread |
| head_tid | output | TID_W | Thread owning the oldest entry |
| head_seq | output | SEQ_W | Sequence number of that entry |
| tail_valid | output | 1 | Tail result names a thread |
| tail_tid | output | TID_W | Thread owning the youngest entry |
| tail_seq | output | SEQ_W | Sequence number of that entry |

## Verification
Random patterns draw sequence numbers either from a narrow range or from the full 16-bit range. The narrow range produces frequent ties, which exposes the tie-break rule and any confusion between strict and non-strict comparison. The full range exercises wide-magnitude comparisons in both the minimum and the maximum scan. Directed cases cover the rest:
- an inactive thread, and a non-empty-flag-clear thread, each holding the most extreme number, which shows whether eligibility filtering is applied;
- all threads ineligible, which separates the none-valid result from stale data;
- inputs changing while the strobes are low, which shows whether each result holds;
- a single eligible thread placed at the last index, which shows the first-valid seeding;
- numbers at 0 and 0xFFFF, which reveal comparisons that are signed or lose a bit.

// File: rtl/thread_end_select_pkg.sv
package thread_end_select_pkg;

    localparam int unsigned DEF_NTHR  = 4;
    localparam int unsigned DEF_SEQ_W = 16;

    // Which extreme a scan keeps.
    typedef enum logic {
        SCAN_MIN = 1'b0,
        SCAN_MAX = 1'b1
    } scan_mode_e;

endpackage

// File: rtl/thread_end_scan.sv
module thread_end_scan
    import thread_end_select_pkg::*;
#(
    parameter int unsigned NTHR  = DEF_NTHR,
    parameter int unsigned SEQ_W = DEF_SEQ_W,
    parameter scan_mode_e  MODE  = SCAN_MIN,
    localparam int unsigned TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic [NTHR-1:0]       elig,
    input  logic [NTHR*SEQ_W-1:0] seqs,
    output logic                  found,
    output logic [TID_W-1:0]      pick_tid,
    output logic [SEQ_W-1:0]      pick_seq
);

    logic [NTHR-1:0] beats;

    // The parameter picks a strict less-than or a strict greater-than.
    // Strict comparison keeps the lower index on a tie.
    genvar gi;
    generate
        for (gi = 0; gi < NTHR; gi++) begin : g_cmp
            if (MODE == SCAN_MIN) begin : g_min
                assign beats[gi] = seqs[gi*SEQ_W +: SEQ_W] < pick_prefix_seq[gi];
            end else begin : g_max
                assign beats[gi] = seqs[gi*SEQ_W +: SEQ_W] > pick_prefix_seq[gi];
            end
        end
    endgenerate

    logic [SEQ_W-1:0] pick_prefix_seq [NTHR];
    logic [NTHR-1:0]  prefix_found;

    // Prefix state seen by each stage: found flag and best value over lower indices.
    always_comb begin
        logic             f;
        logic [SEQ_W-1:0] s;
        f = 1'b0;
        s = '0;
        for (int i = 0; i < NTHR; i++) begin
            prefix_found[i]    = f;
            pick_prefix_seq[i] = s;
            if (elig[i]) begin
                if (!f || (MODE == SCAN_MIN ? (seqs[i*SEQ_W +: SEQ_W] < s)
                                            : (seqs[i*SEQ_W +: SEQ_W] > s))) begin
                    s = seqs[i*SEQ_W +: SEQ_W];
                end
                f = 1'b1;
            end
        end
    end

    // Walk the stages: the first eligible thread seeds, later ones replace on a win.
    always_comb begin
        found    = 1'b0;
        pick_tid = '0;
        pick_seq = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (elig[i] && (!prefix_found[i] || beats[i])) begin
                found    = 1'b1;
                pick_tid = TID_W'(i);
                pick_seq = seqs[i*SEQ_W +: SEQ_W];
            end
        end
    end

endmodule

// File: rtl/thread_end_select.sv
module thread_end_select
    import thread_end_select_pkg::*;
#(
    parameter int unsigned NTHR  = DEF_NTHR,
    parameter int unsigned SEQ_W = DEF_SEQ_W,
    localparam int unsigned TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NTHR-1:0]       thr_active,
    input  logic [NTHR-1:0]       thr_nonempty,
    input  logic [NTHR*SEQ_W-1:0] thr_old_seq,
    input  logic [NTHR*SEQ_W-1:0] thr_young_seq,
    input  logic                  retire_evt,
    input  logic                  tail_evt,
    output logic                  head_valid,
    output logic [TID_W-1:0]      head_tid,
    output logic [SEQ_W-1:0]      head_seq,
    output logic                  tail_valid,
    output logic [TID_W-1:0]      tail_tid,
    output logic [SEQ_W-1:0]      tail_seq
);

    // R6: eligibility needs both flags
    logic [NTHR-1:0] elig;
    assign elig = thr_active & thr_nonempty;

    logic             h_found, t_found;
    logic [TID_W-1:0] h_tid, t_tid;
    logic [SEQ_W-1:0] h_seq, t_seq;

    thread_end_scan #(.NTHR(NTHR), .SEQ_W(SEQ_W), .MODE(SCAN_MIN)) u_head_scan (
        .elig(elig), .seqs(thr_old_seq),
        .found(h_found), .pick_tid(h_tid), .pick_seq(h_seq)
    );

    thread_end_scan #(.NTHR(NTHR), .SEQ_W(SEQ_W), .MODE(SCAN_MAX)) u_tail_scan (
        .elig(elig), .seqs(thr_young_seq),
        .found(t_found), .pick_tid(t_tid), .pick_seq(t_seq)
    );

    // R1, R2, R7, R8: head register, refreshed only on the retire strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            head_valid <= 1'b0;
            head_tid   <= '0;
            head_seq   <= '0;
        end else if (retire_evt) begin
            head_valid <= h_found;
            head_tid   <= h_tid;
            head_seq   <= h_seq;
        end
    end

    // R4, R7, R8, R9: tail register, independent of the head strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            tail_valid <= 1'b0;
            tail_tid   <= '0;
            tail_seq   <= '0;
        end else if (tail_evt) begin
            tail_valid <= t_found;
            tail_tid   <= t_tid;
            tail_seq   <= t_seq;
        end
    end

    // Assertions
    p_head_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!retire_evt) |=> $stable({head_valid, head_tid, head_seq}));

    p_tail_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!tail_evt) |=> $stable({tail_valid, tail_tid, tail_seq}));

    p_head_none_r7: assert property (@(posedge clk) disable iff (rst)
        (retire_evt && (thr_active & thr_nonempty) == '0) |=> (!head_valid && head_seq == '0));

    p_tail_none_r7: assert property (@(posedge clk) disable iff (rst)
        (tail_evt && (thr_active & thr_nonempty) == '0) |=> (!tail_valid && tail_seq == '0));

    p_head_found_r2: assert property (@(posedge clk) disable iff (rst)
        (retire_evt && (thr_active & thr_nonempty) != '0) |=> head_valid);

    p_tail_found_r4: assert property (@(posedge clk) disable iff (rst)
        (tail_evt && (thr_active & thr_nonempty) != '0) |=> tail_valid);

    genvar ai;
    generate
        for (ai = 0; ai < NTHR; ai++) begin : g_chk
            p_head_min_r2: assert property (@(posedge clk) disable iff (rst)
                (retire_evt && thr_active[ai] && thr_nonempty[ai])
                |=> head_seq <= $past(thr_old_seq[ai*SEQ_W +: SEQ_W]));

            p_tail_max_r4: assert property (@(posedge clk) disable iff (rst)
                (tail_evt && thr_active[ai] && thr_nonempty[ai])
                |=> tail_seq >= $past(thr_young_seq[ai*SEQ_W +: SEQ_W]));
        end
    endgenerate

endmodule

// File: tb/sim_thread_end_select.sv
`timescale 1ns/1ps
module sim_thread_end_select;

    localparam int NT = 4;
    localparam int SW = 16;
    localparam int TW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NT-1:0]   act = '0, nem = '0;
    logic [NT*SW-1:0] olds = '0, youngs = '0;
    logic            rev = 1'b0, tev = 1'b0;
    logic            hv, tv;
    logic [TW-1:0]   ht, tt;
    logic [SW-1:0]   hs, ts;

    int n_cmp = 0;
    int n_bad = 0;

    // Expected register contents: {valid, tid, seq}
    logic [SW+TW:0] exp_h = '0, exp_t = '0;

    always #2 clk = ~clk;   // 250 MHz

    thread_end_select u0 (
        .clk(clk), .rst(rst),
        .thr_active(act), .thr_nonempty(nem),
        .thr_old_seq(olds), .thr_young_seq(youngs),
        .retire_evt(rev), .tail_evt(tev),
        .head_valid(hv), .head_tid(ht), .head_seq(hs),
        .tail_valid(tv), .tail_tid(tt), .tail_seq(ts)
    );

    // Reference: strict comparison from thread 0 upward
    function automatic logic [SW+TW:0] ref_pick(input logic [NT-1:0] el,
                                                input logic [NT*SW-1:0] sq,
                                                input bit want_max);
        logic [SW+TW:0] r;
        r = '0;
        for (int i = 0; i < NT; i++) begin
            logic [SW-1:0] v;
            v = sq[i*SW +: SW];
            if (el[i] && (!r[SW+TW] || (want_max ? v > r[SW-1:0] : v < r[SW-1:0])))
                r = {1'b1, TW'(i), v};
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [SW+TW:0] got, input logic [SW+TW:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at the falling edge, update the model, sample 1 ns after the rising edge.
    task automatic step(input logic [NT-1:0] a, input logic [NT-1:0] n,
                        input logic [NT*SW-1:0] o, input logic [NT*SW-1:0] y,
                        input logic r, input logic t, input string tag);
        @(negedge clk);
        act = a; nem = n; olds = o; youngs = y; rev = r; tev = t;
        if (r) exp_h = ref_pick(a & n, o, 1'b0);
        if (t) exp_t = ref_pick(a & n, y, 1'b1);
        @(posedge clk);
        #1;
        check({tag, " head"}, {hv, ht, hs}, exp_h);
        check({tag, " tail"}, {tv, tt, ts}, exp_t);
    endtask

    function automatic logic [NT*SW-1:0] rnd_seqs(input bit narrow);
        logic [NT*SW-1:0] v;
        for (int i = 0; i < NT; i++)
            v[i*SW +: SW] = narrow ? SW'($urandom_range(0, 5)) : SW'($urandom);
        return v;
    endfunction

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset head", {hv, ht, hs}, '0);
        check("R1 reset tail", {tv, tt, ts}, '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after release head", {hv, ht, hs}, '0);
        check("R1 after release tail", {tv, tt, ts}, '0);

        // R2/R4 basic, full-range extremes
        step(4'hF, 4'hF, {16'd40, 16'd7, 16'hFFFF, 16'd0}, {16'd50, 16'd9, 16'hFFFF, 16'd3},
             1, 1, "R2 R4 extremes");
        // R3 R5 ties keep lower index
        step(4'hF, 4'hF, {16'd5, 16'd2, 16'd2, 16'd9}, {16'd8, 16'd8, 16'd1, 16'd3},
             1, 1, "R3 R5 ties");
        // R6 inactive thread with best values is skipped
        step(4'b1101, 4'hF, {16'd30, 16'd20, 16'd1, 16'd25}, {16'd10, 16'd12, 16'd99, 16'd11},
             1, 1, "R6 inactive");
        // R6 empty thread skipped
        step(4'hF, 4'b0111, {16'd0, 16'd20, 16'd30, 16'd25}, {16'hFFFF, 16'd12, 16'd13, 16'd11},
             1, 1, "R6 empty");
        // Seeding: only the last thread eligible
        step(4'b1000, 4'b1000, {16'd77, 16'd1, 16'd1, 16'd1}, {16'd78, 16'd900, 16'd900, 16'd900},
             1, 1, "R2 R4 single last");
        // R8 hold while strobes are low
        step(4'hF, 4'hF, {16'd1, 16'd1, 16'd1, 16'd1}, {16'd500, 16'd500, 16'd500, 16'd500},
             0, 0, "R8 hold");
        // R9 only tail strobe
        step(4'hF, 4'hF, {16'd4, 16'd3, 16'd2, 16'd1}, {16'd4, 16'd3, 16'd2, 16'd1},
             0, 1, "R9 tail only");
        // R9 only head strobe
        step(4'hF, 4'hF, {16'd4, 16'd3, 16'd2, 16'd6}, {16'd4, 16'd3, 16'd2, 16'd1},
             1, 0, "R9 head only");
        // R7 none eligible
        step(4'b0011, 4'b1100, {16'd4, 16'd3, 16'd2, 16'd1}, {16'd4, 16'd3, 16'd2, 16'd1},
             1, 1, "R7 none valid");

        // Random mix, narrow and wide ranges
        for (int k = 0; k < 2000; k++) begin
            bit nar;
            nar = ($urandom_range(0, 1) == 1);
            step(NT'($urandom), NT'($urandom), rnd_seqs(nar), rnd_seqs(nar),
                 1'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule